// File: doc/BRIEF.md
# Programmable Bus Wait-State Inserter

This block stretches an external bus cycle by holding the bus sequencer in its third state for a programmed time. The bus cycle runs through four states, T1 to T4. The wait time is given by a 3-bit code in half-clock wait states. Each nonzero code step adds two half-clock states, which is one full clock cycle. The block counts these half-states in steps of one full clock, so no logic runs on the falling edge.

The sequencer reports its current state to the block. In the first cycle of T3 the block takes a snapshot of three things: the wait code, the internal-access flag and the low-speed-oscillator flag. If the access is external, the fast clock is running and the code is nonzero, the `hold` output rises in that same cycle. It stays high for exactly the programmed number of clocks, and the sequencer then moves on to T4. Inside the block a three-state controller does this work. `WS_IDLE` waits for T3. `WS_STRETCH` counts down the remaining wait. `WS_DONE` keeps the block quiet until the bus leaves T3. The transitions are:
- idle to stretch, on T3 entry with more than one clock of wait;
- idle to done, on T3 entry with a single clock of wait or with the wait suppressed;
- stretch to done, on the last counted clock;
- done to idle, when the bus leaves T3.

Top module: `wait_state_inserter`

## Requirements
- R1: Wait code 000 inserts no wait: `hold` stays low for the whole bus cycle.
- R2: A wait code k from 1 to 7 inserts 2k half-clock wait states. `hold` is high for exactly k consecutive clock cycles, starting in the first T3 cycle.
- R3: `hold` is high only while `bus_state` is T3. The encoding is T1=00, T2=01, T3=10, T4=11.
- R4: If `internal_access` is 1 in the first T3 cycle, no wait is inserted.
- R5: If `slow_clock` is 1 in the first T3 cycle, no wait is inserted.
- R6: The wait code is sampled in the first T3 cycle. Changing `wait_code` during a wait does not change the length of that wait.
- R7: After `hold` drops, it stays low for as long as `bus_state` remains T3. A new wait can start only after the bus has left T3.
- R8: While `rst_n` is low, `hold` is low. The block leaves reset idle with no wait pending.
- R9: Changing `internal_access` or `slow_clock` after the first T3 cycle does not shorten or cancel a wait already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wait_code | input | 3 | Programmed wait code; k gives 2k half-clock states |
| bus_state | input | 2 | Current bus state from the sequencer (00=T1, 01=T2, 10=T3, 11=T4) |
| internal_access | input | 1 | Current access targets an internal register or internal memory |
| slow_clock | input | 1 | System is running from the low-speed oscillator |
| hold | output | 1 | Keeps the sequencer in T3 while high |

## Verification
The checker watches several rules on every cycle:
- `hold` appears only in T3;
- `hold` never rises for code zero, for internal accesses or under the slow clock;
- every high run of `hold` lasts exactly as long as the code captured when it rose;
- once released, `hold` cannot rise again within the same T3;
- `hold` stays silent during reset.

Some behaviours need the bench's scenarios, because they only show up when an input changes in the middle of a wait. These are a code rewrite, or a flip of the internal or slow flag, during a wait: the bench must show that the wait length does not move.

// File: rtl/wsi_pkg.sv
package wsi_pkg;

    // Bus sequencer state as reported to the inserter
    typedef enum logic [1:0] {
        BUS_T1 = 2'b00,
        BUS_T2 = 2'b01,
        BUS_T3 = 2'b10,
        BUS_T4 = 2'b11
    } bus_state_e;

    // Controller states
    typedef enum logic [1:0] {
        WS_IDLE    = 2'b00,
        WS_STRETCH = 2'b01,
        WS_DONE    = 2'b10
    } ws_state_e;

    // Half-clock wait states covered by one full clock
    localparam int unsigned HALVES_PER_CLK = 2;

endpackage

// File: rtl/wsi_code_decode.sv
module wsi_code_decode #(
    parameter int unsigned CODE_W          = 3,
    parameter int unsigned HALVES_PER_STEP = 2,
    parameter int unsigned CNT_W           = 4
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  halves_o,
    output logic              zero_o,
    output logic              single_o
);
    import wsi_pkg::*;

    // Each code step adds HALVES_PER_STEP half-clock wait states
    always_comb begin
        halves_o = CNT_W'(code_i) * CNT_W'(HALVES_PER_STEP);
        zero_o   = (code_i == '0);
        single_o = (halves_o == CNT_W'(HALVES_PER_CLK));
    end

endmodule

// File: rtl/wsi_half_counter.sv
module wsi_half_counter #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             last_o
);
    import wsi_pkg::*;

    localparam logic [CNT_W-1:0] STEP = CNT_W'(HALVES_PER_CLK);

    // Half-states still owed after the current clock
    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load_i) begin
            // The entry cycle itself consumes one clock of wait
            remain_q <= (load_val_i >= STEP) ? (load_val_i - STEP) : '0;
        end else if (dec_i) begin
            remain_q <= (remain_q >= STEP) ? (remain_q - STEP) : '0;
        end
    end

    assign last_o = (remain_q <= STEP);

endmodule

// File: rtl/wsi_seq_fsm.sv
module wsi_seq_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic in_t3_i,
    input  logic eligible_i,
    input  logic zero_i,
    input  logic single_i,
    input  logic last_i,
    output logic load_o,
    output logic dec_o,
    output logic hold_o
);
    import wsi_pkg::*;

    ws_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE: begin
                if (in_t3_i) begin
                    if (eligible_i && !zero_i && !single_i) begin
                        state_d = WS_STRETCH;
                    end else begin
                        state_d = WS_DONE;
                    end
                end
            end
            WS_STRETCH: begin
                if (last_i) begin
                    state_d = WS_DONE;
                end
            end
            WS_DONE: begin
                if (!in_t3_i) begin
                    state_d = WS_IDLE;
                end
            end
            default: state_d = WS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load_o = 1'b0;
        dec_o  = 1'b0;
        hold_o = 1'b0;
        unique case (state_q)
            WS_IDLE: begin
                if (in_t3_i && eligible_i && !zero_i) begin
                    load_o = 1'b1;
                    hold_o = 1'b1;
                end
            end
            WS_STRETCH: begin
                dec_o  = 1'b1;
                hold_o = 1'b1;
            end
            WS_DONE: begin
                hold_o = 1'b0;
            end
            default: begin
                hold_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/wait_state_inserter.sv
module wait_state_inserter #(
    parameter int unsigned CODE_W          = 3,
    parameter int unsigned HALVES_PER_STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] wait_code,
    input  logic [1:0]        bus_state,
    input  logic              internal_access,
    input  logic              slow_clock,
    output logic              hold
);
    import wsi_pkg::*;

    localparam int unsigned MAX_HALVES = ((1 << CODE_W) - 1) * HALVES_PER_STEP;
    localparam int unsigned CNT_W      = $clog2(MAX_HALVES + 1);

    logic             in_t3;
    logic             eligible;
    logic [CNT_W-1:0] halves;
    logic             zero_wait;
    logic             single_wait;
    logic             load;
    logic             dec;
    logic             last;
    logic             fsm_hold;

    assign in_t3    = (bus_state_e'(bus_state) == BUS_T3);
    assign eligible = !internal_access && !slow_clock;

    wsi_code_decode #(
        .CODE_W          (CODE_W),
        .HALVES_PER_STEP (HALVES_PER_STEP),
        .CNT_W           (CNT_W)
    ) decode_i (
        .code_i   (wait_code),
        .halves_o (halves),
        .zero_o   (zero_wait),
        .single_o (single_wait)
    );

    wsi_half_counter #(
        .CNT_W (CNT_W)
    ) counter_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (halves),
        .dec_i      (dec),
        .last_o     (last)
    );

    wsi_seq_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_t3_i    (in_t3),
        .eligible_i (eligible),
        .zero_i     (zero_wait),
        .single_i   (single_wait),
        .last_i     (last),
        .load_o     (load),
        .dec_o      (dec),
        .hold_o     (fsm_hold)
    );

    // Entry-cycle hold is combinational; gate it off while in reset
    assign hold = fsm_hold && rst_n;

endmodule

// File: rtl/wsi_checker.sv
module wsi_checker #(
    parameter int unsigned CODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] wait_code,
    input logic [1:0]        bus_state,
    input logic              internal_access,
    input logic              slow_clock,
    input logic              hold
);
    localparam int unsigned RUN_W = CODE_W + 1;

    logic [RUN_W-1:0]  run_len;
    logic [CODE_W-1:0] lat_code;
    logic              armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len  <= '0;
            lat_code <= '0;
            armed    <= 1'b0;
        end else begin
            armed   <= 1'b1;
            run_len <= hold ? run_len + 1'b1 : '0;
            if (hold && run_len == '0) begin
                lat_code <= wait_code;
            end
        end
    end

    assert_no_wait_code_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> wait_code != '0);

    // Covers R6 as well: the length follows the code captured at the rise
    assert_wait_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> run_len == RUN_W'(lat_code));

    assert_wait_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> run_len < RUN_W'((1 << CODE_W) - 1));

    assert_hold_only_t3_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> bus_state == 2'b10);

    assert_no_hold_internal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> !internal_access);

    assert_no_hold_slow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> !slow_clock);

    assert_no_retrigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && bus_state == 2'b10 && $past(bus_state) == 2'b10 && !$past(hold)) |-> !hold);

    assert_reset_quiet_R8: assert property (@(posedge clk)
        !rst_n |-> !hold);

endmodule

bind wait_state_inserter wsi_checker #(.CODE_W(CODE_W)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .wait_code       (wait_code),
    .bus_state       (bus_state),
    .internal_access (internal_access),
    .slow_clock      (slow_clock),
    .hold            (hold)
);

// File: tb/wait_state_inserter_tb_top.sv
module wait_state_inserter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 14;

    // {code[2:0], internal, slow, expected_clocks[3:0]}
    localparam logic [8:0] VEC [NVEC] = '{
        {3'd0, 1'b0, 1'b0, 4'd0},
        {3'd1, 1'b0, 1'b0, 4'd1},
        {3'd2, 1'b0, 1'b0, 4'd2},
        {3'd3, 1'b0, 1'b0, 4'd3},
        {3'd4, 1'b0, 1'b0, 4'd4},
        {3'd5, 1'b0, 1'b0, 4'd5},
        {3'd6, 1'b0, 1'b0, 4'd6},
        {3'd7, 1'b0, 1'b0, 4'd7},
        {3'd7, 1'b1, 1'b0, 4'd0},
        {3'd3, 1'b1, 1'b0, 4'd0},
        {3'd5, 1'b0, 1'b1, 4'd0},
        {3'd7, 1'b0, 1'b1, 4'd0},
        {3'd2, 1'b1, 1'b1, 4'd0},
        {3'd0, 1'b0, 1'b1, 4'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] wait_code = 3'd0;
    logic [1:0] bus_state = 2'b00;
    logic       internal_access = 1'b0;
    logic       slow_clock = 1'b0;
    logic       hold;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wait_state_inserter dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .wait_code       (wait_code),
        .bus_state       (bus_state),
        .internal_access (internal_access),
        .slow_clock      (slow_clock),
        .hold            (hold)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // Runs one bus cycle; the bench plays the sequencer and stays in T3 while hold is high.
    // mid: after the first wait clock, rewrite the code and flip both flags.
    task automatic bus_access(input logic [2:0] code, input logic intl, input logic slw,
                              input bit mid, input int linger, input int exp_len,
                              input string req);
        int len = 0;
        int early = 0;
        int guard = 0;
        @(negedge clk);
        bus_state = 2'b00; wait_code = code; internal_access = intl; slow_clock = slw;
        #1 early += hold;
        @(negedge clk);
        bus_state = 2'b01;
        #1 early += hold;
        @(negedge clk);
        bus_state = 2'b10;
        #1;
        while (hold && guard < 40) begin
            len++;
            guard++;
            @(negedge clk);
            if (mid) begin
                wait_code = ~code; internal_access = ~intl; slow_clock = ~slw;
            end
            #1;
        end
        if (guard >= 40) begin
            check("watchdog", guard, 0);
        end
        check(req, len, exp_len);
        check("R3 no hold in T1/T2", early, 0);
        for (int i = 0; i < linger; i++) begin
            @(negedge clk);
            #1 check("R7 no retrigger in T3", int'(hold), 0);
        end
        @(negedge clk);
        bus_state = 2'b11; internal_access = 1'b0; slow_clock = 1'b0;
        #1 check("R3 no hold in T4", int'(hold), 0);
    endtask

    initial begin
        // R8: reset holds the output low even with a wait-ready T3
        bus_state = 2'b10; wait_code = 3'd5;
        repeat (3) @(negedge clk);
        #1 check("R8 hold low in reset", int'(hold), 0);
        bus_state = 2'b00;
        @(negedge clk);
        rst_n = 1'b1;
        #1 check("R8 idle after reset", int'(hold), 0);

        // Table walk: R1, R2, R4, R5
        for (int v = 0; v < NVEC; v++) begin
            bus_access(VEC[v][8:6], VEC[v][5], VEC[v][4], 1'b0, 0, int'(VEC[v][3:0]),
                       "R1/R2/R4/R5 table wait length");
        end

        // R6 and R9: inputs change during the wait
        bus_access(3'd3, 1'b0, 1'b0, 1'b1, 0, 3, "R6 R9 code/flags change mid-wait, code 3");
        bus_access(3'd6, 1'b0, 1'b0, 1'b1, 0, 6, "R6 R9 code/flags change mid-wait, code 6");

        // R7: linger in T3 after release, then a fresh access still waits
        bus_access(3'd2, 1'b0, 1'b0, 1'b0, 4, 2, "R7 wait before linger");
        bus_access(3'd1, 1'b0, 1'b0, 1'b0, 3, 1, "R7 single wait with linger");
        bus_access(3'd4, 1'b0, 1'b0, 1'b0, 0, 4, "R7 next access after linger");
        // R5 suppressed entry lingering in T3 stays quiet
        bus_access(3'd7, 1'b0, 1'b1, 1'b0, 3, 0, "R5 slow entry with linger");

        // R8: reset in mid-wait drops hold
        @(negedge clk);
        wait_code = 3'd7; bus_state = 2'b10;
        @(negedge clk);
        rst_n = 1'b0;
        #1 check("R8 reset mid-wait clears hold", int'(hold), 0);
        bus_state = 2'b00;
        @(negedge clk);
        rst_n = 1'b1;
        bus_access(3'd2, 1'b0, 1'b0, 1'b0, 0, 2, "R8 R2 wait after mid-wait reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule